// File: doc/BRIEF.md
# Bit-Plane Sequencer for a Charge-Domain Compute Array

This block drives the dense, analog accumulation path of a compute-in-memory macro. An input vector reaches it one bit plane at a time. Each plane holds one bit per word line, and plane 0 carries weight 1. For every plane the block does four things in order. It clears the compute bit lines with a one-cycle strobe. It then drives the compute word lines from the plane for one cycle. Next it fires a conversion request to the column converters. Last, it holds the word-line drivers idle until the conversion is over.

The converters run on a slower clock than the array, so one conversion spans a number of array cycles. That number is set by `CONV_CYCLES`. The converters sit outside the block and return one `ADC_W`-bit code per column, flagged by a valid pulse. The block captures that code and shifts it left by the plane's index. It adds the shifted code into a per-column accumulator. After the last plane it raises a one-cycle done pulse.

The upstream source offers planes with a valid and takes them on the ready. The vector's start is marked with `start_i`.

Top module: `bitplane_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `cbl_rst_o`, `cwl_en_o`, `adc_start_o`, `done_o` and `plane_ready_o` are 0, `cwl_o` is 0 and every accumulator is 0. No vector is active until `start_i` is seen.
- R2: `start_i` in the idle state with no vector active clears all accumulators and the plane index. `plane_ready_o` is high in that same cycle, so a plane offered in that cycle is taken as plane 0. `plane_ready_o` is also high in idle cycles between planes of an active vector. `start_i` at any other time is ignored.
- R3: The cycle after a plane is accepted (`plane_valid_i` and `plane_ready_o` both high), `cbl_rst_o` is high for exactly one cycle.
- R4: The cycle after the reset strobe, `cwl_en_o` is high for exactly one cycle and `cwl_o` equals the plane bits captured at acceptance. Later changes on `plane_bits_i` do not reach it. `cwl_o` is 0 whenever `cwl_en_o` is low.
- R5: The cycle after the drive cycle, `adc_start_o` pulses for one cycle and the conversion phase begins. Let L be the number of cycles from `adc_start_o` to the first `adc_valid_i`. The phase lasts max(`CONV_CYCLES`, L+1) cycles. Throughout it, `cwl_en_o`, `cbl_rst_o` and `plane_ready_o` stay low and no plane is accepted.
- R6: Only the first `adc_valid_i` within a conversion phase is used. Further valid pulses in the same phase, and valid pulses outside any conversion phase, leave the accumulators unchanged.
- R7: When a conversion phase ends, each column's accumulator (column c at `acc_o[c*ACC_W +: ACC_W]`) adds the captured code (`adc_data_i[c*ADC_W +: ADC_W]`) shifted left by the plane index. `ACC_W` = `ADC_W` + `NUM_PLANES`, so all-ones codes on every plane do not overflow.
- R8: `done_o` is a one-cycle pulse in the first cycle after the last plane's conversion phase. That cycle is also the first in which `acc_o` holds the final sums. After it, `plane_ready_o` stays low and the accumulators hold their value until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Array clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new vector |
| plane_valid_i | input | 1 | A bit plane is offered |
| plane_bits_i | input | NUM_ROWS | Bit plane, one bit per word line |
| plane_ready_o | output | 1 | Plane is taken this cycle if offered |
| adc_valid_i | input | 1 | Converter result valid |
| adc_data_i | input | NUM_COLS*ADC_W | Converter codes, column c at bits c*ADC_W |
| cbl_rst_o | output | 1 | Compute bit-line reset strobe |
| cwl_en_o | output | 1 | Compute word-line drive enable |
| cwl_o | output | NUM_ROWS | Compute word-line levels |
| adc_start_o | output | 1 | Conversion request strobe |
| done_o | output | 1 | Vector complete pulse |
| acc_o | output | NUM_COLS*ACC_W | Per-column shifted partial sums |

## Verification
Two things can land in the same cycle. The first is the start of a vector and the acceptance of its first plane. The bench always raises `start_i` together with plane 0. It then checks that the accumulators read zero and the reset strobe appears in the very next cycle. The second is the converter's valid pulse and the expiry of the minimum conversion wait. Converter latencies are chosen below, at and above `CONV_CYCLES`-1 so that the valid pulse comes early, lands on the final wait cycle, or extends the phase. The phase length and the accumulated sums are judged against max(`CONV_CYCLES`, L+1) and a shift-and-add model computed in the bench.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_DRIVE = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int NUM_PLANES  = 8,
  parameter int CONV_CYCLES = 9,
  parameter int IDX_W       = $clog2(NUM_PLANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             plane_valid_i,
  input  logic             adc_valid_i,
  input  logic             got_i,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] plane_idx_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             clear_o,
  output logic             conv_first_o,
  output logic             conv_end_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PLANES - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             active_q, done_q, last_plane;

  assign last_plane   = (idx_q == IDX_LAST);
  assign ready_o      = (st_q == ST_IDLE) && (active_q || start_i);
  assign accept_o     = ready_o && plane_valid_i;
  assign clear_o      = (st_q == ST_IDLE) && start_i && !active_q;
  assign conv_first_o = (st_q == ST_CONV) && (cnt_q == '0);
  // converter must both have answered and have had its full minimum window
  assign conv_end_o   = (st_q == ST_CONV) && (cnt_q == CNT_LAST) && (got_i || adc_valid_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_o) st_d = ST_RESET;
      ST_RESET: st_d = ST_DRIVE;
      ST_DRIVE: st_d = ST_CONV;
      ST_CONV:  if (conv_end_o) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= conv_end_o && last_plane;
      if (st_q == ST_DRIVE) cnt_q <= '0;
      else if (st_q == ST_CONV && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
      if (clear_o) begin
        idx_q    <= '0;
        active_q <= 1'b1;
      end else if (conv_end_o) begin
        if (last_plane) active_q <= 1'b0;
        else            idx_q    <= idx_q + 1'b1;
      end
    end
  end

  assign state_o     = st_q;
  assign plane_idx_o = idx_q;
  assign done_o      = done_q;
endmodule

// File: rtl/bps_capture.sv
module bps_capture #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_conv_i,
  input  logic         conv_end_i,
  input  logic         adc_valid_i,
  input  logic [W-1:0] adc_data_i,
  output logic         got_o,
  output logic [W-1:0] result_o
);
  logic         got_q;
  logic [W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= 1'b0;
      res_q <= '0;
    end else if (conv_end_i) begin
      got_q <= 1'b0;
    end else if (in_conv_i && adc_valid_i && !got_q) begin
      got_q <= 1'b1;
      res_q <= adc_data_i;
    end
  end

  // a result arriving on the last wait cycle is used straight from the port
  assign got_o    = got_q;
  assign result_o = got_q ? res_q : adc_data_i;
endmodule

// File: rtl/bps_col_acc.sv
module bps_col_acc #(
  parameter int NUM_COLS = 4,
  parameter int ADC_W    = 8,
  parameter int ACC_W    = 16,
  parameter int IDX_W    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      add_i,
  input  logic [IDX_W-1:0]          shift_i,
  input  logic [NUM_COLS*ADC_W-1:0] code_i,
  output logic [NUM_COLS*ACC_W-1:0] acc_o
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] term;

    assign term = ACC_W'(code_i[c*ADC_W +: ADC_W]) << shift_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (add_i)   acc_q <= acc_q + term;
    end

    assign acc_o[c*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
  import bps_pkg::*;
#(
  parameter int NUM_ROWS    = 16,
  parameter int NUM_COLS    = 4,
  parameter int ADC_W       = 8,
  parameter int NUM_PLANES  = 8,
  parameter int CONV_CYCLES = 9,
  parameter int ACC_W       = ADC_W + NUM_PLANES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      plane_valid_i,
  input  logic [NUM_ROWS-1:0]       plane_bits_i,
  output logic                      plane_ready_o,
  input  logic                      adc_valid_i,
  input  logic [NUM_COLS*ADC_W-1:0] adc_data_i,
  output logic                      cbl_rst_o,
  output logic                      cwl_en_o,
  output logic [NUM_ROWS-1:0]       cwl_o,
  output logic                      adc_start_o,
  output logic                      done_o,
  output logic [NUM_COLS*ACC_W-1:0] acc_o
);
  localparam int IDX_W  = $clog2(NUM_PLANES);
  localparam int CODE_W = NUM_COLS * ADC_W;

  seq_state_e          st;
  logic [IDX_W-1:0]    plane_idx;
  logic                accept, clear, conv_first, conv_end, got;
  logic [CODE_W-1:0]   code;
  logic [NUM_ROWS-1:0] plane_q;

  bps_ctrl #(
    .NUM_PLANES (NUM_PLANES),
    .CONV_CYCLES(CONV_CYCLES),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .plane_valid_i(plane_valid_i),
    .adc_valid_i  (adc_valid_i),
    .got_i        (got),
    .state_o      (st),
    .plane_idx_o  (plane_idx),
    .ready_o      (plane_ready_o),
    .accept_o     (accept),
    .clear_o      (clear),
    .conv_first_o (conv_first),
    .conv_end_o   (conv_end),
    .done_o       (done_o)
  );

  bps_capture #(.W(CODE_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_conv_i  (st == ST_CONV),
    .conv_end_i (conv_end),
    .adc_valid_i(adc_valid_i),
    .adc_data_i (adc_data_i),
    .got_o      (got),
    .result_o   (code)
  );

  bps_col_acc #(
    .NUM_COLS(NUM_COLS),
    .ADC_W   (ADC_W),
    .ACC_W   (ACC_W),
    .IDX_W   (IDX_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .add_i  (conv_end),
    .shift_i(plane_idx),
    .code_i (code),
    .acc_o  (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     plane_q <= '0;
    else if (accept) plane_q <= plane_bits_i;
  end

  assign cbl_rst_o   = (st == ST_RESET);
  assign cwl_en_o    = (st == ST_DRIVE);
  assign cwl_o       = cwl_en_o ? plane_q : '0;
  assign adc_start_o = conv_first;
endmodule

// File: rtl/bitplane_seq_chk.sv
module bitplane_seq_chk #(
  parameter int NUM_ROWS    = 16,
  parameter int NUM_COLS    = 4,
  parameter int CONV_CYCLES = 9,
  parameter int ACC_W       = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic                      plane_valid_i,
  input logic                      plane_ready_o,
  input logic                      cbl_rst_o,
  input logic                      cwl_en_o,
  input logic [NUM_ROWS-1:0]       cwl_o,
  input logic                      adc_start_o,
  input logic                      done_o,
  input logic [NUM_COLS*ACC_W-1:0] acc_o
);
  localparam int WW = $clog2(CONV_CYCLES + 1);
  localparam logic [WW-1:0] WMAX = WW'(CONV_CYCLES);

  logic          in_conv_q;
  logic [WW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_conv_q <= 1'b0;
      wait_q    <= '0;
    end else if (adc_start_o) begin
      in_conv_q <= 1'b1;
      wait_q    <= WW'(1);
    end else if (plane_ready_o || done_o) begin
      in_conv_q <= 1'b0;
    end else if (in_conv_q && wait_q != WMAX) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  a_r3_rst_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plane_valid_i && plane_ready_o |=> cbl_rst_o && !cwl_en_o);
  a_r4_drive_after_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbl_rst_o |=> cwl_en_o && !cbl_rst_o);
  a_r4_lines_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cwl_en_o |-> cwl_o == '0);
  a_r5_conv_after_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwl_en_o |=> adc_start_o && !cwl_en_o);
  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cbl_rst_o, cwl_en_o, adc_start_o, done_o}));
  a_r5_not_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbl_rst_o || cwl_en_o || adc_start_o) |-> !plane_ready_o);
  a_r5_min_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_conv_q && (plane_ready_o || done_o) |-> wait_q >= WMAX);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(acc_o));
endmodule

bind bitplane_seq bitplane_seq_chk #(
  .NUM_ROWS   (NUM_ROWS),
  .NUM_COLS   (NUM_COLS),
  .CONV_CYCLES(CONV_CYCLES),
  .ACC_W      (ACC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .plane_valid_i(plane_valid_i),
  .plane_ready_o(plane_ready_o),
  .cbl_rst_o    (cbl_rst_o),
  .cwl_en_o     (cwl_en_o),
  .cwl_o        (cwl_o),
  .adc_start_o  (adc_start_o),
  .done_o       (done_o),
  .acc_o        (acc_o)
);

// File: tb/bitplane_seq_test.sv
module bitplane_seq_test;
  localparam int ROWS   = 16;
  localparam int COLS   = 4;
  localparam int ADC_W  = 8;
  localparam int PLANES = 8;
  localparam int CONV   = 9;
  localparam int ACC_W  = ADC_W + PLANES;

  // seed, converter latency, duplicate valid, stray start during conversion
  localparam int NVEC = 5;
  localparam int TBL[NVEC][4] = '{
    '{1,   3,  1, 0},
    '{0,   8,  0, 0},
    '{77,  12, 0, 1},
    '{200, 0,  0, 0},
    '{45,  9,  0, 0}
  };

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic                   plane_valid_i = 1'b0;
  logic [ROWS-1:0]        plane_bits_i = '0;
  logic                   plane_ready_o;
  logic                   adc_valid_i = 1'b0;
  logic [COLS*ADC_W-1:0]  adc_data_i = '0;
  logic                   cbl_rst_o, cwl_en_o, adc_start_o, done_o;
  logic [ROWS-1:0]        cwl_o;
  logic [COLS*ACC_W-1:0]  acc_o;

  int n_chk = 0;
  int n_err = 0;
  logic [ACC_W-1:0] last_acc [COLS];

  always #10 clk = ~clk;

  bitplane_seq #(
    .NUM_ROWS(ROWS), .NUM_COLS(COLS), .ADC_W(ADC_W),
    .NUM_PLANES(PLANES), .CONV_CYCLES(CONV)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .plane_valid_i(plane_valid_i), .plane_bits_i(plane_bits_i),
    .plane_ready_o(plane_ready_o), .adc_valid_i(adc_valid_i),
    .adc_data_i(adc_data_i), .cbl_rst_o(cbl_rst_o), .cwl_en_o(cwl_en_o),
    .cwl_o(cwl_o), .adc_start_o(adc_start_o), .done_o(done_o), .acc_o(acc_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ROWS-1:0] pbits(input int seed, input int p);
    return ROWS'((seed * 131 + p * 2749 + 17) ^ (p << 3));
  endfunction

  function automatic int adat(input int seed, input int p, input int c);
    if (seed == 0) return 255;
    return (seed * 7 + p * 37 + c * 11 + 5) % 256;
  endfunction

  function automatic logic [ACC_W-1:0] col(input int c);
    return acc_o[c*ACC_W +: ACC_W];
  endfunction

  task automatic run_vec(input int seed, input int lat, input int dup, input int restart);
    logic [ACC_W-1:0] exp_acc [COLS];
    int len;
    len = (lat + 1 > CONV) ? lat + 1 : CONV;
    for (int c = 0; c < COLS; c++) begin
      exp_acc[c] = '0;
      for (int p = 0; p < PLANES; p++) exp_acc[c] += ACC_W'(adat(seed, p, c)) << p;
    end
    @(negedge clk);
    start_i = 1'b1; plane_valid_i = 1'b1; plane_bits_i = pbits(seed, 0);
    #1 chk(plane_ready_o == 1'b1, "R2 ready with start", plane_ready_o, 1);
    for (int p = 0; p < PLANES; p++) begin
      @(negedge clk);
      start_i = 1'b0;
      #1;
      if (p == 0)
        for (int c = 0; c < COLS; c++) chk(col(c) == '0, "R2 clear on start", col(c), 0);
      chk(cbl_rst_o && !cwl_en_o, "R3 reset strobe", cbl_rst_o, 1);
      if (p < PLANES - 1) plane_bits_i = pbits(seed, p + 1);
      else                plane_valid_i = 1'b0;
      @(negedge clk); #1;
      chk(cwl_en_o && !cbl_rst_o, "R4 drive enable", cwl_en_o, 1);
      chk(cwl_o == pbits(seed, p), "R4 word lines", cwl_o, pbits(seed, p));
      @(negedge clk);
      for (int k = 0; k < len; k++) begin
        adc_valid_i = (k == lat) || (dup != 0 && k == lat + 1);
        for (int c = 0; c < COLS; c++)
          adc_data_i[c*ADC_W +: ADC_W] = (k == lat) ? ADC_W'(adat(seed, p, c)) : 8'hA5;
        start_i = (restart != 0 && p == 1 && k == 2);
        #1;
        chk(adc_start_o == (k == 0), "R5 conversion strobe", adc_start_o, k == 0);
        chk(!cwl_en_o && !cbl_rst_o && !plane_ready_o, "R5 drivers idle in conversion",
            {cwl_en_o, cbl_rst_o, plane_ready_o}, 0);
        @(negedge clk);
      end
      adc_valid_i = 1'b0; start_i = 1'b0;
      #1;
      if (p < PLANES - 1) begin
        chk(plane_ready_o && !done_o, "R5 conversion length", plane_ready_o, 1);
      end else begin
        chk(done_o == 1'b1, "R8 done after last plane", done_o, 1);
        chk(plane_ready_o == 1'b0, "R8 no ready after vector", plane_ready_o, 0);
        for (int c = 0; c < COLS; c++) begin
          chk(col(c) == exp_acc[c], "R7 R6 shifted accumulate", col(c), exp_acc[c]);
          last_acc[c] = exp_acc[c];
        end
      end
    end
    @(negedge clk); #1;
    chk(done_o == 1'b0, "R8 done is a pulse", done_o, 0);
    for (int c = 0; c < COLS; c++) chk(col(c) == last_acc[c], "R8 hold after done", col(c), last_acc[c]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    chk({cbl_rst_o, cwl_en_o, adc_start_o, done_o, plane_ready_o} == '0, "R1 strobes in reset",
        {cbl_rst_o, cwl_en_o, adc_start_o, done_o, plane_ready_o}, 0);
    chk(cwl_o == '0 && acc_o == '0, "R1 lines and sums in reset", acc_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    plane_valid_i = 1'b1;
    #1 chk(plane_ready_o == 1'b0, "R1 no vector before start", plane_ready_o, 0);
    @(negedge clk); #1;
    chk(cbl_rst_o == 1'b0, "R1 plane without start ignored", cbl_rst_o, 0);
    plane_valid_i = 1'b0;

    for (int i = 0; i < NVEC; i++) run_vec(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);

    // stray converter result and plane while idle after a vector
    @(negedge clk);
    adc_valid_i = 1'b1; adc_data_i = '1; plane_valid_i = 1'b1;
    #1 chk(plane_ready_o == 1'b0, "R8 idle after vector", plane_ready_o, 0);
    @(negedge clk);
    adc_valid_i = 1'b0; plane_valid_i = 1'b0;
    #1 chk(cbl_rst_o == 1'b0, "R2 no plane without start", cbl_rst_o, 0);
    for (int c = 0; c < COLS; c++) chk(col(c) == last_acc[c], "R6 stray valid ignored", col(c), last_acc[c]);

    // asynchronous reset clears held sums
    #3 rst_ni = 1'b0;
    #1 chk(acc_o == '0 && !done_o, "R1 reset clears sums", acc_o, 0);
    @(negedge clk) rst_ni = 1'b1;

    // reset in the middle of a conversion
    @(negedge clk);
    start_i = 1'b1; plane_valid_i = 1'b1; plane_bits_i = 16'hBEEF;
    @(negedge clk); start_i = 1'b0; plane_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 chk({cbl_rst_o, cwl_en_o, adc_start_o, done_o, plane_ready_o} == '0 && cwl_o == '0,
           "R1 reset mid conversion", {cbl_rst_o, cwl_en_o, adc_start_o}, 0);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(plane_ready_o == 1'b0 && !cwl_en_o, "R1 vector dropped by reset", plane_ready_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule